// File: doc/BRIEF.md
# Cascaded Dual-Loop Digital Compensator

This block is the arithmetic core of a digitally controlled current-mode buck regulator. On every sample strobe it takes three signed samples: the output-voltage reference, the measured output voltage and the measured inductor current. It produces one duty-cycle command word. The outer loop subtracts the measured voltage from the reference and filters that error through a second-order recursive section. The section's output is the current demand. The inner loop subtracts the measured inductor current from that demand and filters the difference through a second recursive section. Its output is limited to the usable duty range and handed to the PWM generator together with a one-cycle valid pulse.

Both sections are direct-form-I difference equations with two past inputs and two past outputs. Each section has its own coefficient fraction width. Software supplies each coefficient already quantized by a halve, scale and floor rule. A signed word `h` with `n` fraction bits stands for the real coefficient `2*h/2^n`, so a section's sum of products is shifted right by `n-1` with floor rounding. Strobes typically arrive at twice the switching frequency, for example 200 kHz at 100 kHz switching. A full update finishes in the strobe's own clock cycle, so strobes may come as often as every cycle.

Top module: `dual_loop_comp`

## Requirements
- R1: The voltage error is `vref_i - vout_i`, saturated to the signed `SMP_W`-bit range (-2^(SMP_W-1) .. 2^(SMP_W-1)-1) instead of wrapping.
- R2: The current error is the voltage section's new output minus `il_i`, saturated to the same signed `SMP_W`-bit range.
- R3: Each section computes `y = floor((h0*e + h1*e1 + h2*e2 + g1*y1 + g2*y2) / 2^(n-1))`. Here e1, e2 are its previous two inputs, y1, y2 its previous two stored outputs, and n its fraction width (`VFRAC` for the voltage section, `IFRAC` for the current section). The accumulator never overflows.
- R4: The voltage section's output is clamped to signed `SMP_W` bits and the current section's output to signed `DUTY_W+2` bits. The clamped value is the one stored as the section's past output.
- R5: `duty_o` is the current section's output limited to 0 .. `DMAX`: negative values give 0 and values above `DMAX` give `DMAX`.
- R6: A strobe sampled high on a rising edge updates both sections. `duty_o` takes the new value and `duty_vld_o` is high for exactly the following cycle. Without a strobe, no state changes and `duty_o` holds.
- R7: A synchronous active-high `rst` clears all past inputs and outputs of both sections, sets `duty_o` to 0 and drops `duty_vld_o`.
- R8: Each coefficient bus packs five signed words of `FRAC+1` bits. Field k sits at bits `[k*(FRAC+1) +: FRAC+1]`, in the order k=0 current-input gain h0, 1 gain h1 on the previous input, 2 gain h2 on the input before that, 3 feedback g1 on the previous output, 4 feedback g2 on the output before that. Feedback words enter with a plus sign.
- R9: Loaded with the quantized outer filter (0.312 z^2 + 0.0066 z - 0.3054)/(z^2 - 1.872 z + 0.872) at `VFRAC`=12 and the quantized inner filter (0.0037 z^2 + 0.003 z - 0.0034)/(z^2 - 1.429 z + 0.429) at `IFRAC`=14, a constant positive voltage error with zero inductor current drives `duty_o` up to `DMAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| vref_i | input | SMP_W | Signed output-voltage reference |
| vout_i | input | SMP_W | Signed measured output voltage |
| il_i | input | SMP_W | Signed measured inductor current |
| vcoef_i | input | 5*(VFRAC+1) | Packed voltage-section coefficients |
| icoef_i | input | 5*(IFRAC+1) | Packed current-section coefficients |
| duty_o | output | DUTY_W | Duty-cycle command, 0 .. DMAX |
| duty_vld_o | output | 1 | High for the cycle after each processed strobe |

## Verification
Unit pass-through coefficients make each output equal to the saturated error, which separates the two subtractors and their saturation (R1, R2) from the filter arithmetic. Putting a single unit coefficient into one field at a time shows whether the field packing and the delay line are wired in the right order (R8). A pure integrator held at full error, then unwound with negative steps, shows whether the section clamp acts on stored state (R4) rather than only on the duty limit. The stated filter pair under a constant error checks the integrating climb to the duty ceiling (R9). Random coefficients and random samples, compared step by step with an integer model, exercise sign handling and floor rounding across the whole range (R3).

// File: rtl/dlc_pkg.sv
package dlc_pkg;
   localparam int NCOEF = 5;

   typedef enum int {
      K_B0 = 0,
      K_B1 = 1,
      K_B2 = 2,
      K_G1 = 3,
      K_G2 = 4
   } coef_idx_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // product width plus three guard bits for the sum of five terms
   function automatic int acc_width(input int cw, input int xw, input int yw);
      return cw + max2(xw, yw) + 3;
   endfunction
endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
   parameter int IW = 16,
   parameter int OW = 8
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);
   generate
      if (IW <= OW) begin : g_extend
         assign dout = OW'(din);
      end else begin : g_clamp
         localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
         localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};
         always_comb begin
            if (din > HI)      dout = HI[OW-1:0];
            else if (din < LO) dout = LO[OW-1:0];
            else               dout = din[OW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/err_sat.sv
module err_sat #(
   parameter int W = 10
) (
   input  logic signed [W-1:0] minuend,
   input  logic signed [W-1:0] subtrahend,
   output logic signed [W-1:0] diff
);
   logic signed [W:0] wide;

   assign wide = {minuend[W-1], minuend} - {subtrahend[W-1], subtrahend};

   sat_narrow #(.IW(W+1), .OW(W)) u_sat (.din(wide), .dout(diff));
endmodule

// File: rtl/iir2_df1.sv
module iir2_df1
   import dlc_pkg::*;
#(
   parameter int XW   = 10,
   parameter int YW   = 10,
   parameter int FRAC = 12,
   parameter int CW   = FRAC + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [XW-1:0]    x,
   input  logic [NCOEF*CW-1:0]     coef,
   output logic signed [YW-1:0]    y
);
   localparam int ACC_W = acc_width(CW, XW, YW);

   generate
      if (FRAC < 2) begin : g_bad_frac
         $error("iir2_df1: FRAC must be at least 2");
      end
      if (ACC_W > 62) begin : g_bad_acc
         $error("iir2_df1: accumulator too wide");
      end
   endgenerate

   logic signed [XW-1:0] x1_q, x2_q;
   logic signed [YW-1:0] y1_q, y2_q;

   logic signed [ACC_W-1:0] tap_v [NCOEF];
   logic signed [ACC_W-1:0] tap_c [NCOEF];
   logic signed [ACC_W-1:0] prod  [NCOEF];
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] scaled;

   assign tap_v[K_B0] = ACC_W'(x);
   assign tap_v[K_B1] = ACC_W'(x1_q);
   assign tap_v[K_B2] = ACC_W'(x2_q);
   assign tap_v[K_G1] = ACC_W'(y1_q);
   assign tap_v[K_G2] = ACC_W'(y2_q);

   generate
      for (genvar k = 0; k < NCOEF; k++) begin : g_tap
         assign tap_c[k] = ACC_W'($signed(coef[k*CW +: CW]));
         assign prod[k]  = tap_c[k] * tap_v[k];
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < NCOEF; k++) acc = acc + prod[k];
   end

   // stored words are half the real coefficient: restore with a shift of FRAC-1
   assign scaled = acc >>> (FRAC - 1);

   sat_narrow #(.IW(ACC_W), .OW(YW)) u_clamp (.din(scaled), .dout(y));

   always_ff @(posedge clk) begin
      if (rst) begin
         x1_q <= '0;
         x2_q <= '0;
         y1_q <= '0;
         y2_q <= '0;
      end else if (en) begin
         x1_q <= x;
         x2_q <= x1_q;
         y1_q <= y;
         y2_q <= y1_q;
      end
   end
endmodule

// File: rtl/duty_limit.sv
module duty_limit #(
   parameter int IW     = 12,
   parameter int DUTY_W = 10,
   parameter int DMAX   = 900
) (
   input  logic signed [IW-1:0] din,
   output logic [DUTY_W-1:0]    duty
);
   localparam logic signed [IW-1:0] CEIL = IW'(DMAX);

   always_comb begin
      if (din < 0)         duty = '0;
      else if (din > CEIL) duty = DUTY_W'(DMAX);
      else                 duty = din[DUTY_W-1:0];
   end
endmodule

// File: rtl/dual_loop_comp.sv
module dual_loop_comp
   import dlc_pkg::*;
#(
   parameter int SMP_W  = 10,
   parameter int VFRAC  = 12,
   parameter int IFRAC  = 14,
   parameter int DUTY_W = 10,
   parameter int DMAX   = 900
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          smp_stb,
   input  logic signed [SMP_W-1:0]       vref_i,
   input  logic signed [SMP_W-1:0]       vout_i,
   input  logic signed [SMP_W-1:0]       il_i,
   input  logic [NCOEF*(VFRAC+1)-1:0]    vcoef_i,
   input  logic [NCOEF*(IFRAC+1)-1:0]    icoef_i,
   output logic [DUTY_W-1:0]             duty_o,
   output logic                          duty_vld_o
);
   localparam int VCW  = VFRAC + 1;
   localparam int ICW  = IFRAC + 1;
   localparam int CO_W = DUTY_W + 2;

   generate
      if (SMP_W < 4) begin : g_bad_smp
         $error("dual_loop_comp: SMP_W too small");
      end
      if (DMAX < 1 || DMAX >= (1 << DUTY_W)) begin : g_bad_dmax
         $error("dual_loop_comp: DMAX outside duty word");
      end
   endgenerate

   logic signed [SMP_W-1:0] verr_w;
   logic signed [SMP_W-1:0] iref_w;
   logic signed [SMP_W-1:0] ierr_w;
   logic signed [CO_W-1:0]  ictl_w;
   logic [DUTY_W-1:0]       duty_w;
   logic [DUTY_W-1:0]       duty_q;
   logic                    vld_q;

   err_sat #(.W(SMP_W)) u_verr (
      .minuend(vref_i), .subtrahend(vout_i), .diff(verr_w));

   iir2_df1 #(.XW(SMP_W), .YW(SMP_W), .FRAC(VFRAC), .CW(VCW)) u_vsec (
      .clk(clk), .rst(rst), .en(smp_stb),
      .x(verr_w), .coef(vcoef_i), .y(iref_w));

   err_sat #(.W(SMP_W)) u_ierr (
      .minuend(iref_w), .subtrahend(il_i), .diff(ierr_w));

   iir2_df1 #(.XW(SMP_W), .YW(CO_W), .FRAC(IFRAC), .CW(ICW)) u_isec (
      .clk(clk), .rst(rst), .en(smp_stb),
      .x(ierr_w), .coef(icoef_i), .y(ictl_w));

   duty_limit #(.IW(CO_W), .DUTY_W(DUTY_W), .DMAX(DMAX)) u_lim (
      .din(ictl_w), .duty(duty_w));

   always_ff @(posedge clk) begin
      if (rst) begin
         duty_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= smp_stb;
         if (smp_stb) duty_q <= duty_w;
      end
   end

   assign duty_o     = duty_q;
   assign duty_vld_o = vld_q;
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
   parameter int SMP_W  = 10,
   parameter int DUTY_W = 10,
   parameter int DMAX   = 900
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    stb,
   input logic signed [SMP_W-1:0] vref,
   input logic signed [SMP_W-1:0] vout,
   input logic signed [SMP_W-1:0] il,
   input logic signed [SMP_W-1:0] verr,
   input logic signed [SMP_W-1:0] iref,
   input logic signed [SMP_W-1:0] ierr,
   input logic [DUTY_W-1:0]       duty,
   input logic                    vld
);
   // R1: error sign follows the reference/measurement ordering
   a_r1_verr_sign: assert property (@(posedge clk) disable iff (rst)
      (vref >= vout) |-> (verr >= 0));

   // R2: current error sign follows demand/measurement ordering
   a_r2_ierr_sign: assert property (@(posedge clk) disable iff (rst)
      (iref >= il) |-> (ierr >= 0));

   // R5: duty never above ceiling
   a_r5_duty_cap: assert property (@(posedge clk) disable iff (rst)
      duty <= DUTY_W'(DMAX));

   // R6: strobe produces a valid pulse next cycle
   a_r6_vld_follows: assert property (@(posedge clk) disable iff (rst)
      stb |=> vld);

   // R6: valid only after a strobe
   a_r6_vld_cause: assert property (@(posedge clk) disable iff (rst)
      vld |-> $past(stb));

   // R6: duty holds without a strobe
   a_r6_duty_hold: assert property (@(posedge clk) disable iff (rst)
      !stb |=> $stable(duty));
endmodule

bind dual_loop_comp dlc_checker #(.SMP_W(SMP_W), .DUTY_W(DUTY_W), .DMAX(DMAX)) u_chk (
   .clk(clk), .rst(rst), .stb(smp_stb),
   .vref(vref_i), .vout(vout_i), .il(il_i),
   .verr(verr_w), .iref(iref_w), .ierr(ierr_w),
   .duty(duty_o), .vld(duty_vld_o));

// File: tb/sim_dual_loop_comp.sv
module sim_dual_loop_comp;
   localparam int SMP_W  = 10;
   localparam int VFRAC  = 12;
   localparam int IFRAC  = 14;
   localparam int DUTY_W = 10;
   localparam int DMAX   = 900;
   localparam int VCW    = VFRAC + 1;
   localparam int ICW    = IFRAC + 1;
   localparam int CO_W   = DUTY_W + 2;

   logic                     clk = 1'b0;
   logic                     rst = 1'b1;
   logic                     stb = 1'b0;
   logic signed [SMP_W-1:0]  vref = '0, vout = '0, il = '0;
   logic [5*VCW-1:0]         vcoef = '0;
   logic [5*ICW-1:0]         icoef = '0;
   logic [DUTY_W-1:0]        duty;
   logic                     vld;

   int checks = 0;
   int errors = 0;

   longint vh [5];
   longint ih [5];
   longint vx1, vx2, vy1, vy2, ix1, ix2, iy1, iy2;
   longint exp_duty;

   always #4 clk = ~clk;

   dual_loop_comp #(.SMP_W(SMP_W), .VFRAC(VFRAC), .IFRAC(IFRAC),
                    .DUTY_W(DUTY_W), .DMAX(DMAX)) u0 (
      .clk(clk), .rst(rst), .smp_stb(stb),
      .vref_i(vref), .vout_i(vout), .il_i(il),
      .vcoef_i(vcoef), .icoef_i(icoef),
      .duty_o(duty), .duty_vld_o(vld));

   function automatic longint satw(input longint v, input int w);
      longint hi = (64'sd1 <<< (w-1)) - 1;
      longint lo = -(64'sd1 <<< (w-1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic longint qcoef(input real c, input int n);
      return longint'($floor(c / 2.0 * (2.0 ** n)));
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic load_coefs();
      for (int k = 0; k < 5; k++) begin
         vcoef[k*VCW +: VCW] = VCW'(vh[k]);
         icoef[k*ICW +: ICW] = ICW'(ih[k]);
      end
   endtask

   task automatic model_clear();
      vx1 = 0; vx2 = 0; vy1 = 0; vy2 = 0;
      ix1 = 0; ix2 = 0; iy1 = 0; iy2 = 0;
      exp_duty = 0;
   endtask

   task automatic model_step(input longint r, input longint o, input longint c);
      longint e, a, yv, ie, yi;
      e  = satw(r - o, SMP_W);
      a  = vh[0]*e + vh[1]*vx1 + vh[2]*vx2 + vh[3]*vy1 + vh[4]*vy2;
      yv = satw(a >>> (VFRAC-1), SMP_W);
      vx2 = vx1; vx1 = e; vy2 = vy1; vy1 = yv;
      ie = satw(yv - c, SMP_W);
      a  = ih[0]*ie + ih[1]*ix1 + ih[2]*ix2 + ih[3]*iy1 + ih[4]*iy2;
      yi = satw(a >>> (IFRAC-1), CO_W);
      ix2 = ix1; ix1 = ie; iy2 = iy1; iy1 = yi;
      exp_duty = (yi < 0) ? 0 : ((yi > DMAX) ? DMAX : yi);
   endtask

   task automatic sample(input int r, input int o, input int c, input string req);
      @(negedge clk);
      vref = SMP_W'(r); vout = SMP_W'(o); il = SMP_W'(c);
      stb = 1'b1;
      model_step(r, o, c);
      @(negedge clk);
      stb = 1'b0;
      chk(vld == 1'b1, "R6 valid after strobe", vld, 1);
      chk(duty == DUTY_W'(exp_duty), req, duty, exp_duty);
      @(negedge clk);
      chk(vld == 1'b0, "R6 valid single cycle", vld, 0);
      chk(duty == DUTY_W'(exp_duty), "R6 duty holds", duty, exp_duty);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      model_clear();
      chk(duty == '0, "R7 duty cleared", duty, 0);
      chk(vld == 1'b0, "R7 valid cleared", vld, 0);
   endtask

   task automatic set_unit(input int vk, input int ik);
      for (int k = 0; k < 5; k++) begin vh[k] = 0; ih[k] = 0; end
      vh[vk] = 64'sd1 <<< (VFRAC-1);
      ih[ik] = 64'sd1 <<< (IFRAC-1);
      load_coefs();
   endtask

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20140));
      model_clear();
      set_unit(0, 0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(duty == '0, "R7 reset duty", duty, 0);
      chk(vld == 1'b0, "R7 reset valid", vld, 0);

      // R1/R2: pass-through exposes subtractors and saturation
      sample(100, 40, 10, "R1 R2 plain difference");
      sample(300, -300, -100, "R1 positive saturation");
      sample(-512, 511, 0, "R1 negative saturation R5 floor");
      sample(200, 0, -400, "R2 current error saturation");

      // R6: idle cycles leave output untouched
      repeat (5) begin
         @(negedge clk);
         chk(duty == DUTY_W'(exp_duty), "R6 idle hold", duty, exp_duty);
      end

      // R8: one field at a time
      do_reset();
      set_unit(1, 0);
      sample(50, 0, 0, "R8 field1 first");
      sample(80, 0, 0, "R8 field1 delayed");
      do_reset();
      set_unit(2, 0);
      sample(60, 0, 0, "R8 field2 a");
      sample(90, 0, 0, "R8 field2 b");
      sample(10, 0, 0, "R8 field2 c");
      do_reset();
      set_unit(0, 3);
      sample(70, 0, 0, "R8 field3 accumulate");
      sample(70, 0, 0, "R8 field3 accumulate 2");

      // R4: inner integrator clamps then unwinds
      do_reset();
      set_unit(0, 0);
      ih[3] = 64'sd1 <<< (IFRAC-1);
      load_coefs();
      for (int s = 0; s < 6; s++) sample(511, 0, -512, "R4 drive into clamp");
      for (int s = 0; s < 3; s++) sample(-512, 0, 0, "R4 unwind from clamped state");
      chk(duty == DUTY_W'(511), "R4 clamped state", duty, 511);

      // R9: the stated filter pair
      do_reset();
      vh[0] = qcoef(0.312, VFRAC);   vh[1] = qcoef(0.0066, VFRAC);
      vh[2] = qcoef(-0.3054, VFRAC); vh[3] = qcoef(1.872, VFRAC);
      vh[4] = qcoef(-0.872, VFRAC);
      ih[0] = qcoef(0.0037, IFRAC);  ih[1] = qcoef(0.003, IFRAC);
      ih[2] = qcoef(-0.0034, IFRAC); ih[3] = qcoef(1.429, IFRAC);
      ih[4] = qcoef(-0.429, IFRAC);
      load_coefs();
      for (int s = 0; s < 600; s++) sample(200, 100, 0, "R9 R3 stated filters");
      chk(duty == DUTY_W'(DMAX), "R9 reaches ceiling", duty, DMAX);

      // R3: random coefficients and samples
      do_reset();
      for (int blk = 0; blk < 6; blk++) begin
         for (int k = 0; k < 5; k++) begin
            vh[k] = longint'($urandom_range(2*4095)) - 4095;
            ih[k] = longint'($urandom_range(2*16383)) - 16383;
         end
         load_coefs();
         for (int s = 0; s < 50; s++)
            sample(int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512,
                   int'($urandom_range(1023)) - 512, "R3 R5 random");
      end

      // R7: reset mid-run clears state
      do_reset();
      sample(30, 10, 5, "R7 state cleared after reset");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule